// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Array

This block is a purely combinational arithmetic unit that folds a fixed set of operand ports into one result. Each port is set at elaboration time to be either a plain addend or the product of two operands, to be signed or unsigned, and to be added or subtracted. A group of single-bit inputs is summed as well, each with weight one.

All partial products, inverted subtract terms and their correction constants become rows of a common array. A tree of 3:2 full-adder rows shrinks that array level by level until two rows are left, and one carry-propagate adder gives the final value. The single-bit inputs do not take whole rows: they occupy the empty least significant bit that each shifted carry row leaves, and then the carry-in of the final adder. The result wraps modulo two to the power of the output width.

Top module: `macc_array`

## Requirements
- R1: `y` equals the sum of all configured terms plus the single-bit inputs, taken modulo 2^OUT_W. Port p takes operand A from `a_in[p*A_SLOT +: A_W[p]]` and operand B from `b_in[p*B_SLOT +: B_W[p]]`. Bit p of IS_MUL selects a product (1) or a plain addend A (0).
- R2: Bit p of IS_SGN set means the port's operands are two's-complement values, sign-extended to the output width. Clear means zero-extended.
- R3: Bit p of IS_SUB set means the port's term is subtracted, so its two's-complement negation is added.
- R4: A product is correct whichever operand is wider. The wider operand acts as the multiplicand and the narrower one supplies the AND-gated rows.
- R5: In a signed product the multiplier's most significant bit carries negative weight. The most-negative times most-negative case therefore gives the positive product.
- R6: Each bit of `bit_in` adds exactly 1 to the result. With all operands zero, `y` equals the number of set bits of `bit_in`.
- R7: When every input is zero, `y` is zero, including the ports that are subtracted.
- R8: Sums that exceed the output range wrap around with no saturation. All-ones and most-negative operands give the truncated exact sum.
- R9: `y` depends only on the present inputs. It settles within the same clock period as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | NPORT*A_SLOT | Operand A slots, one per port; low A_W[p] bits used |
| b_in | input | NPORT*B_SLOT | Operand B slots, one per port; low B_W[p] bits used for products |
| bit_in | input | NBIT | Single-bit addends, each of weight 1 |
| y | output | OUT_W | Modular sum of all terms |

## Verification
Three effects can land on the same column in the same evaluation: single-bit addends occupy the vacated carry LSBs, subtract corrections add ones at bit 0, and signed-product correction rows add terms at the multiplier MSB position. The bench provokes this by driving most-negative and all-ones operands on every port together with all single-bit inputs set, then by mixing those settings at random. Each result is judged against a sign-correct reference sum that the bench computes with wide integers and truncates to the output width.

// File: rtl/macc_pkg.sv
package macc_pkg;

    // Row count after one 3:2 level (groups of three become two rows).
    function automatic int tree_next(input int n);
        if (n <= 2) return n;
        return 2 * (n / 3) + (n % 3);
    endfunction

    // Row count at reduction level k, starting from n0 rows.
    function automatic int tree_count(input int n0, input int k);
        int n;
        n = n0;
        for (int j = 0; j < k; j++) n = tree_next(n);
        return n;
    endfunction

    // Number of levels needed to reach two rows.
    function automatic int tree_levels(input int n0);
        int n;
        int lv;
        n  = n0;
        lv = 0;
        while (n > 2) begin
            n  = tree_next(n);
            lv = lv + 1;
        end
        return lv;
    endfunction

    // Full-adder groups used in all levels below k (global carry-slot base).
    function automatic int groups_before(input int n0, input int k);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) s = s + tree_count(n0, j) / 3;
        return s;
    endfunction

endpackage

// File: rtl/macc_csa_row.sv
module macc_csa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         fill,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;
    logic         unused_msb;

    assign s          = x ^ y ^ z;
    assign maj        = (x & y) | (x & z) | (y & z);
    // carry moves up one column; the vacated LSB takes a single-bit addend
    assign c          = {maj[W-2:0], fill};
    assign unused_msb = maj[W-1];
endmodule

// File: rtl/macc_term_rows.sv
module macc_term_rows #(
    parameter int OUT_W  = 16,
    parameter int AW     = 8,
    parameter int BW     = 8,
    parameter int A_SLOT = 8,
    parameter int B_SLOT = 8,
    parameter bit MUL    = 1'b1,
    parameter bit SGN    = 1'b0,
    parameter bit SUB    = 1'b0,
    parameter int NROWS  = 8
) (
    input  logic [A_SLOT-1:0]            a_slot,
    input  logic [B_SLOT-1:0]            b_slot,
    output logic [NROWS-1:0][OUT_W-1:0]  rows
);
    localparam bit SWAP = (BW > AW);
    localparam int MC_W = SWAP ? BW : AW;
    localparam int MP_W = SWAP ? AW : BW;

    logic [NROWS-1:0][OUT_W-1:0] raw;
    logic                        unused_term;

    assign unused_term = ^{a_slot, b_slot};

    generate
        if (MUL) begin : g_mul
            logic [MC_W-1:0]  mc;
            logic [MP_W-1:0]  mp;
            logic [OUT_W-1:0] mc_ext;

            if (SWAP) begin : g_swap
                assign mc = b_slot[BW-1:0];
                assign mp = a_slot[AW-1:0];
            end else begin : g_keep
                assign mc = a_slot[AW-1:0];
                assign mp = b_slot[BW-1:0];
            end

            assign mc_ext = OUT_W'({{64{SGN & mc[MC_W-1]}}, mc});

            for (genvar i = 0; i < MP_W; i++) begin : g_pp
                if (SGN && (i == MP_W - 1)) begin : g_neg
                    // negative-weight row: inverted shifted multiplicand plus mp[i] at column i
                    assign raw[i]    = {OUT_W{mp[i]}} & ((~mc_ext) << i);
                    assign raw[MP_W] = {{(OUT_W-1){1'b0}}, mp[i]} << i;
                end else begin : g_pos
                    assign raw[i] = {OUT_W{mp[i]}} & (mc_ext << i);
                end
            end
        end else begin : g_add
            assign raw[0] = OUT_W'({{64{SGN & a_slot[AW-1]}}, a_slot[AW-1:0]});
        end

        for (genvar r = 0; r < NROWS; r++) begin : g_sub
            // subtraction: invert here, the +1 per row is gathered in the constant row
            assign rows[r] = SUB ? ~raw[r] : raw[r];
        end
    endgenerate
endmodule

// File: rtl/macc_csa_tree.sv
module macc_csa_tree
    import macc_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int NR    = 4
) (
    input  logic [NR-1:0][OUT_W-1:0] rows_in,
    input  logic [NR-2:0]            slot,
    output logic [OUT_W-1:0]         fin_x,
    output logic [OUT_W-1:0]         fin_y
);
    localparam int LV = tree_levels(NR);

    logic [NR-1:0][OUT_W-1:0] lvl [LV+1];
    logic                     unused_tree;

    assign lvl[0] = rows_in;

    generate
        for (genvar k = 0; k < LV; k++) begin : g_lvl
            localparam int N    = tree_count(NR, k);
            localparam int G    = N / 3;
            localparam int R    = N % 3;
            localparam int BASE = groups_before(NR, k);
            localparam int NN   = 2 * G + R;

            for (genvar g = 0; g < G; g++) begin : g_grp
                macc_csa_row #(.W(OUT_W)) u_row (
                    .x    (lvl[k][3*g]),
                    .y    (lvl[k][3*g+1]),
                    .z    (lvl[k][3*g+2]),
                    .fill (slot[BASE+g]),
                    .s    (lvl[k+1][2*g]),
                    .c    (lvl[k+1][2*g+1])
                );
            end
            for (genvar r = 0; r < R; r++) begin : g_pass
                assign lvl[k+1][2*G+r] = lvl[k][3*G+r];
            end
            for (genvar j = NN; j < NR; j++) begin : g_zero
                assign lvl[k+1][j] = '0;
            end
        end
    endgenerate

    assign fin_x       = lvl[LV][0];
    assign fin_y       = lvl[LV][1];
    assign unused_tree = ^{lvl[LV], slot};
endmodule

// File: rtl/macc_array.sv
module macc_array
    import macc_pkg::*;
#(
    parameter int       OUT_W  = 16,
    parameter int       NPORT  = 5,
    parameter int       A_SLOT = 12,
    parameter int       B_SLOT = 8,
    parameter int       NBIT   = 3,
    parameter int       A_W [NPORT] = '{8, 6, 12, 10, 4},
    parameter int       B_W [NPORT] = '{8, 5, 1, 1, 7},
    parameter bit [NPORT-1:0] IS_MUL = 5'b10011,
    parameter bit [NPORT-1:0] IS_SGN = 5'b10110,
    parameter bit [NPORT-1:0] IS_SUB = 5'b01010
) (
    input  logic [NPORT*A_SLOT-1:0] a_in,
    input  logic [NPORT*B_SLOT-1:0] b_in,
    input  logic [NBIT-1:0]         bit_in,
    output logic [OUT_W-1:0]        y
);
    function automatic int rows_of(input int p);
        int mw;
        mw = (A_W[p] < B_W[p]) ? A_W[p] : B_W[p];
        return IS_MUL[p] ? (mw + int'(IS_SGN[p])) : 1;
    endfunction

    function automatic int base_of(input int p);
        int s;
        s = 0;
        for (int q = 0; q < p; q++) s = s + rows_of(q);
        return s;
    endfunction

    function automatic int const_ones();
        int s;
        s = 0;
        for (int q = 0; q < NPORT; q++) if (IS_SUB[q]) s = s + rows_of(q);
        return s;
    endfunction

    localparam int NR_PORTS = base_of(NPORT);
    localparam int CONST_V  = const_ones();
    localparam int NR0      = NR_PORTS + 1;
    localparam int NEXTRA   = (NBIT > NR0 - 1) ? (NBIT - (NR0 - 1)) : 0;
    localparam int NR       = NR0 + NEXTRA;
    localparam int NSLOT    = NR - 1;

    logic [NR-1:0][OUT_W-1:0] rows0;
    logic [NSLOT-1:0]         slot_bits;
    logic [OUT_W-1:0]         fin_x;
    logic [OUT_W-1:0]         fin_y;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam int BASE = base_of(p);
            localparam int NRW  = rows_of(p);
            macc_term_rows #(
                .OUT_W  (OUT_W),
                .AW     (A_W[p]),
                .BW     (B_W[p]),
                .A_SLOT (A_SLOT),
                .B_SLOT (B_SLOT),
                .MUL    (IS_MUL[p]),
                .SGN    (IS_SGN[p]),
                .SUB    (IS_SUB[p]),
                .NROWS  (NRW)
            ) u_term (
                .a_slot (a_in[p*A_SLOT +: A_SLOT]),
                .b_slot (b_in[p*B_SLOT +: B_SLOT]),
                .rows   (rows0[BASE +: NRW])
            );
        end

        for (genvar e = 0; e < NEXTRA; e++) begin : g_xrow
            assign rows0[NR_PORTS+e] = {{(OUT_W-1){1'b0}}, bit_in[e]};
        end

        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            if (NEXTRA + s < NBIT) begin : g_used
                assign slot_bits[s] = bit_in[NEXTRA+s];
            end else begin : g_idle
                assign slot_bits[s] = 1'b0;
            end
        end
    endgenerate

    // gathered +1 corrections of all subtracted rows
    assign rows0[NR-1] = OUT_W'(CONST_V);

    macc_csa_tree #(.OUT_W(OUT_W), .NR(NR)) u_tree (
        .rows_in (rows0),
        .slot    (slot_bits),
        .fin_x   (fin_x),
        .fin_y   (fin_y)
    );

    // last free slot is the carry-in of the final adder
    assign y = fin_x + fin_y + {{(OUT_W-1){1'b0}}, slot_bits[NSLOT-1]};
endmodule

// File: rtl/macc_array_chk.sv
module macc_array_chk #(
    parameter int       OUT_W  = 16,
    parameter int       NPORT  = 5,
    parameter int       A_SLOT = 12,
    parameter int       B_SLOT = 8,
    parameter int       NBIT   = 3,
    parameter int       NR     = 4,
    parameter int       A_W [NPORT] = '{8, 6, 12, 10, 4},
    parameter int       B_W [NPORT] = '{8, 5, 1, 1, 7},
    parameter bit [NPORT-1:0] IS_MUL = 5'b10011,
    parameter bit [NPORT-1:0] IS_SGN = 5'b10110,
    parameter bit [NPORT-1:0] IS_SUB = 5'b01010
) (
    input logic [NPORT*A_SLOT-1:0]  a_in,
    input logic [NPORT*B_SLOT-1:0]  b_in,
    input logic [NBIT-1:0]          bit_in,
    input logic [NR-1:0][OUT_W-1:0] rows0,
    input logic [NR-2:0]            slot,
    input logic [OUT_W-1:0]         fin_x,
    input logic [OUT_W-1:0]         fin_y,
    input logic [OUT_W-1:0]         y
);
    logic [63:0] ref_sum;
    logic [63:0] tree_in;
    logic [63:0] tree_out;

    always_comb begin
        logic [63:0] av;
        logic [63:0] bv;
        logic [63:0] t;
        ref_sum = '0;
        for (int p = 0; p < NPORT; p++) begin
            av = 64'(a_in[p*A_SLOT +: A_SLOT]) & ((64'd1 << A_W[p]) - 64'd1);
            bv = 64'(b_in[p*B_SLOT +: B_SLOT]) & ((64'd1 << B_W[p]) - 64'd1);
            if (IS_SGN[p] && av[A_W[p]-1]) av = av - (64'd1 << A_W[p]);
            if (IS_SGN[p] && bv[B_W[p]-1]) bv = bv - (64'd1 << B_W[p]);
            t = IS_MUL[p] ? av * bv : av;
            ref_sum = IS_SUB[p] ? ref_sum - t : ref_sum + t;
        end
        ref_sum = ref_sum + 64'($countones(bit_in));

        tree_in = '0;
        for (int r = 0; r < NR; r++) tree_in = tree_in + 64'(rows0[r]);
        for (int s = 0; s < NR - 2; s++) tree_in = tree_in + 64'(slot[s]);
        tree_out = 64'(fin_x) + 64'(fin_y);

        // R1: output matches the sign-correct modular sum
        p_result_r1: assert (y == OUT_W'(ref_sum))
            else $error("R1 result %h expected %h", y, OUT_W'(ref_sum));
        // R1: 3:2 reduction keeps the column sum of its input rows and carry slots
        p_tree_conserve_r1: assert (OUT_W'(tree_in) == OUT_W'(tree_out))
            else $error("R1 tree in %h out %h", OUT_W'(tree_in), OUT_W'(tree_out));
        // R7: all-zero inputs give zero
        p_zero_in_r7: assert (!((a_in == '0) && (b_in == '0) && (bit_in == '0)) || (y == '0))
            else $error("R7 zero inputs gave %h", y);
        // R6: with zero operands the result counts the single-bit inputs
        p_bits_only_r6: assert (!((a_in == '0) && (b_in == '0)) || (y == OUT_W'($countones(bit_in))))
            else $error("R6 bits-only result %h", y);
    end
endmodule

bind macc_array macc_array_chk #(
    .OUT_W  (OUT_W),
    .NPORT  (NPORT),
    .A_SLOT (A_SLOT),
    .B_SLOT (B_SLOT),
    .NBIT   (NBIT),
    .NR     (NR),
    .A_W    (A_W),
    .B_W    (B_W),
    .IS_MUL (IS_MUL),
    .IS_SGN (IS_SGN),
    .IS_SUB (IS_SUB)
) u_chk (
    .a_in   (a_in),
    .b_in   (b_in),
    .bit_in (bit_in),
    .rows0  (rows0),
    .slot   (slot_bits),
    .fin_x  (fin_x),
    .fin_y  (fin_y),
    .y      (y)
);

// File: tb/macc_array_tb_top.sv
module macc_array_tb_top;
    localparam int OUT_W  = 16;
    localparam int NPORT  = 5;
    localparam int A_SLOT = 12;
    localparam int B_SLOT = 8;
    localparam int NBIT   = 3;
    localparam int TA [NPORT] = '{8, 6, 12, 10, 4};
    localparam int TB [NPORT] = '{8, 5, 1, 1, 7};
    localparam bit [NPORT-1:0] T_MUL = 5'b10011;
    localparam bit [NPORT-1:0] T_SGN = 5'b10110;
    localparam bit [NPORT-1:0] T_SUB = 5'b01010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPORT*A_SLOT-1:0] a_in  = '0;
    logic [NPORT*B_SLOT-1:0] b_in  = '0;
    logic [NBIT-1:0]         bit_in = '0;
    logic [OUT_W-1:0]        y;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    macc_array dut_i (
        .a_in   (a_in),
        .b_in   (b_in),
        .bit_in (bit_in),
        .y      (y)
    );

    function automatic logic [OUT_W-1:0] model(
        input logic [NPORT*A_SLOT-1:0] a,
        input logic [NPORT*B_SLOT-1:0] b,
        input logic [NBIT-1:0]         bits
    );
        longint acc;
        longint va;
        longint vb;
        longint t;
        acc = 0;
        for (int p = 0; p < NPORT; p++) begin
            va = 0;
            vb = 0;
            for (int i = 0; i < TA[p]; i++) if (a[p*A_SLOT+i]) va = va + (longint'(1) << i);
            for (int i = 0; i < TB[p]; i++) if (b[p*B_SLOT+i]) vb = vb + (longint'(1) << i);
            if (T_SGN[p] && a[p*A_SLOT+TA[p]-1]) va = va - (longint'(1) << TA[p]);
            if (T_SGN[p] && b[p*B_SLOT+TB[p]-1]) vb = vb - (longint'(1) << TB[p]);
            t   = T_MUL[p] ? va * vb : va;
            acc = T_SUB[p] ? acc - t : acc + t;
        end
        for (int i = 0; i < NBIT; i++) acc = acc + longint'(bits[i]);
        return acc[OUT_W-1:0];
    endfunction

    task automatic check_now(input string req);
        logic [OUT_W-1:0] exp_y;
        exp_y = model(a_in, b_in, bit_in);
        n_chk++;
        if (y !== exp_y) begin
            n_fail++;
            $display("FAIL %s: y=%h expected %h (a=%h b=%h bits=%b)", req, y, exp_y, a_in, b_in, bit_in);
        end
    endtask

    task automatic apply(
        input logic [NPORT*A_SLOT-1:0] a,
        input logic [NPORT*B_SLOT-1:0] b,
        input logic [NBIT-1:0]         bits,
        input string                   req
    );
        @(negedge clk);
        a_in   = a;
        b_in   = b;
        bit_in = bits;
        #1;
        check_now(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [NPORT*A_SLOT-1:0] a_port(input int p, input logic [A_SLOT-1:0] v);
        logic [NPORT*A_SLOT-1:0] r;
        r = '0;
        r[p*A_SLOT +: A_SLOT] = v;
        return r;
    endfunction

    function automatic logic [NPORT*B_SLOT-1:0] b_port(input int p, input logic [B_SLOT-1:0] v);
        logic [NPORT*B_SLOT-1:0] r;
        r = '0;
        r[p*B_SLOT +: B_SLOT] = v;
        return r;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        finish_run();
    end

    initial begin : stim
        logic [NPORT*A_SLOT-1:0] amin;
        logic [NPORT*B_SLOT-1:0] bmin;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check_now("R7 zero during reset");
        rst = 1'b0;

        apply('0, '0, '0, "R7 all zero inputs");
        apply('0, '0, 3'b101, "R6 two single bits");
        apply('0, '0, 3'b111, "R6 all single bits");
        apply('0, '0, 3'b010, "R6 one single bit");

        apply(a_port(2, 12'h800), '0, '0, "R2 signed addend most negative");
        apply(a_port(3, 12'h3FF), '0, '0, "R3 unsigned subtracted addend all ones");
        apply(a_port(2, 12'h7FF), '0, 3'b001, "R2 signed addend max positive");
        apply(a_port(0, 12'h0FF), b_port(0, 8'hFF), '0, "R8 unsigned product all ones");
        apply(a_port(1, 12'h020), b_port(1, 8'h10), '0, "R5 signed subtracted product most negative");
        apply(a_port(4, 12'h008), b_port(4, 8'h40), '0, "R5 signed product most negative");
        apply(a_port(4, 12'h003), b_port(4, 8'h45), '0, "R4 product with wider B operand");
        apply(a_port(4, 12'h00F), b_port(4, 8'h7F), 3'b011, "R4 wider B minus one times minus one");
        apply(a_port(1, 12'h001), b_port(1, 8'h1F), '0, "R3 subtracted product of negative multiplier");

        amin = '0;
        bmin = '0;
        for (int p = 0; p < NPORT; p++) begin
            amin[p*A_SLOT + TA[p] - 1] = 1'b1;
            bmin[p*B_SLOT + TB[p] - 1] = 1'b1;
        end
        apply(amin, bmin, 3'b111, "R8 most negative on all ports with all bits");
        apply('1, '1, 3'b111, "R8 all ones on all ports with all bits");
        apply(amin, '1, '0, "R2 most negative A with all-ones B");

        // R9: output follows a new input within the same period, no edge in between
        @(negedge clk);
        a_in   = a_port(0, 12'h012);
        b_in   = b_port(0, 8'h34);
        bit_in = '0;
        #0.5;
        check_now("R9 settles before next edge");
        a_in = a_port(0, 12'h0AB);
        #0.5;
        check_now("R9 follows second change without edge");

        for (int n = 0; n < 400; n++) begin
            logic [NPORT*A_SLOT-1:0] ra;
            logic [NPORT*B_SLOT-1:0] rb;
            for (int w = 0; w < NPORT; w++) begin
                ra[w*A_SLOT +: A_SLOT] = A_SLOT'($urandom);
                rb[w*B_SLOT +: B_SLOT] = B_SLOT'($urandom);
                case ($urandom % 8)
                    0: ra[w*A_SLOT +: A_SLOT] = '0;
                    1: ra[w*A_SLOT +: A_SLOT] = amin[w*A_SLOT +: A_SLOT];
                    2: rb[w*B_SLOT +: B_SLOT] = '1;
                    default: ;
                endcase
            end
            apply(ra, rb, NBIT'($urandom), "R1 random mix");
        end

        finish_run();
    end
endmodule